// File: doc/BRIEF.md
# AER Command Sequencer

This block plays a stream of tagged command words and turns it into timed address-event traffic. It can stand in for a missing neural chip, or it can inject stimulus spikes into a multi-chip network. An external FIFO holds the command words. The sequencer pulls one word at a time and decodes a 2-bit opcode. It then emits an event, counts time ticks, waits for an absolute time value or stops. The system time counter and its tick strobe come from outside the block.

A mode input is captured at the start pulse and selects the output path for the whole run:
- In AER mode, each event goes out on a four-phase request/acknowledge handshake.
- In bypass mode, each event goes out on a valid/ready port that feeds the routing stage's arbiter directly.

Top module: `aer_cmd_seq`

## Requirements
- R1: While reset is held, `busy`, `aerReq`, `bypValid` and `fifoRead` are all low, even when the FIFO reports data.
- R2: A `startPulse` while idle starts execution. A `startPulse` while busy is ignored and changes neither the event stream nor the number of words consumed.
- R3: A command word is `FIELD_W+2` bits wide. Bits [FIELD_W+1:FIELD_W] carry the opcode and bits [FIELD_W-1:0] carry the field. Opcode 2'b00 stops execution: `busy` falls and no further word is taken from the FIFO, even if words remain.
- R4: Opcode 2'b01 emits one event whose address is the 16-bit field. Events leave in command order.
- R5: Opcode 2'b10 waits for as many `timeTick` pulses as the field value before the next word is fetched. A field of zero waits no ticks.
- R6: Opcode 2'b11 suspends execution until the first `timeTick` cycle on which `sysTime[15:0]` equals the field. The next command follows that tick.
- R7: In AER mode, `aerReq` stays high until `aerAck` is seen high and falls the cycle after. No new word is fetched while `aerAck` is still high.
- R8: In bypass mode, events appear only on `bypValid`/`bypAddr`. `bypValid` holds with a stable address until `bypReady`, and `aerReq` never rises. In AER mode, `bypValid` never rises.
- R9: A fetch that finds the FIFO empty ends execution (`busy` falls) without asserting `fifoRead`.
- R10: `busy` is high from the cycle after the accepted start pulse until execution ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to begin executing the FIFO contents |
| bypassMode | input | 1 | Captured at start: 1 sends events to the bypass port, 0 to the AER handshake |
| fifoData | input | FIELD_W+2 (18) | Head word of the command FIFO (show-ahead) |
| fifoEmpty | input | 1 | FIFO holds no word |
| fifoRead | output | 1 | Pops the head word at the next clock edge |
| sysTime | input | TIME_W (32) | System time counter |
| timeTick | input | 1 | One-cycle pulse per system time step |
| aerReq | output | 1 | AER request, four-phase |
| aerAddr | output | FIELD_W (16) | AER event address |
| aerAck | input | 1 | AER acknowledge |
| bypValid | output | 1 | Bypass event valid |
| bypAddr | output | FIELD_W (16) | Bypass event address |
| bypReady | input | 1 | Bypass consumer ready |
| busy | output | 1 | Execution in progress |

## Verification
Most internal faults show up at the first event after them:
- A corrupted delay count or time comparison moves the `sysTime` value at which the next request rises.
- A wrong opcode decode drops, adds or reorders addresses.
- A wrong mode latch sends an event out on the wrong port.

Faults in termination show up only when the run ends, as a wrong number of words left in the FIFO or as `busy` never falling. For that reason every run closes with a leftover-word count and a busy check. Time ticks are spaced so that each one lands while the sequencer is plainly inside a delay or wait, which makes the expected event time exact.

// File: rtl/aer_seq_pkg.sv
package aer_seq_pkg;

  // Opcode in the two top bits of a command word
  typedef enum logic [1:0] {
    OP_END   = 2'b00,
    OP_EMIT  = 2'b01,
    OP_DELAY = 2'b10,
    OP_WAIT  = 2'b11
  } opCode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_AER_REQ,
    ST_AER_REL,
    ST_BYP,
    ST_DELAY,
    ST_WAIT
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic latchMode;
    logic loadDelay;
    logic decDelay;
  } dpStrobe_t;

endpackage

// File: rtl/aer_seq_dp.sv
module aer_seq_dp
  import aer_seq_pkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int TIME_W  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [FIELD_W+1:0]   fifoData,
  input  logic                 bypassIn,
  input  logic [TIME_W-1:0]    sysTime,
  input  logic                 timeTick,
  output opCode_e              opCode,
  output logic [FIELD_W-1:0]   evAddr,
  output logic                 fieldZero,
  output logic                 delayLast,
  output logic                 timeMatch,
  output logic                 modeBypass
);

  localparam int CMD_W = FIELD_W + 2;

  logic [CMD_W-1:0]   cmdReg;
  logic [FIELD_W-1:0] delayCnt;
  logic               modeReg;
  logic [FIELD_W-1:0] field;
  logic [FIELD_W-1:0] timeLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= '0;
      delayCnt <= '0;
      modeReg  <= 1'b0;
    end else begin
      if (strb.loadCmd)   cmdReg  <= fifoData;
      if (strb.latchMode) modeReg <= bypassIn;
      if (strb.loadDelay) begin
        delayCnt <= cmdReg[FIELD_W-1:0];
      end else if (strb.decDelay && (delayCnt != '0)) begin
        delayCnt <= delayCnt - FIELD_W'(1);
      end
    end
  end

  assign field      = cmdReg[FIELD_W-1:0];
  assign opCode     = opCode_e'(cmdReg[CMD_W-1:CMD_W-2]);
  assign evAddr     = field;
  assign fieldZero  = (field == '0);
  assign delayLast  = (delayCnt == FIELD_W'(1));
  assign modeBypass = modeReg;

  // Width of the time value picks how the comparison slice is formed
  generate
    if (TIME_W > FIELD_W) begin : g_timeWide
      logic unusedTimeHi;
      assign timeLow      = sysTime[FIELD_W-1:0];
      assign unusedTimeHi = ^sysTime[TIME_W-1:FIELD_W];
    end else if (TIME_W == FIELD_W) begin : g_timeEqual
      assign timeLow = sysTime;
    end else begin : g_timeNarrow
      assign timeLow = {{(FIELD_W-TIME_W){1'b0}}, sysTime};
    end
  endgenerate

  assign timeMatch = timeTick && (timeLow == field);

  // The delay counter moves only after a tick, except when it is being loaded
  AST_DELAY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (delayCnt != $past(delayCnt)) && !$past(strb.loadDelay) |-> $past(timeTick)); // R5

endmodule

// File: rtl/aer_seq_ctrl.sv
module aer_seq_ctrl
  import aer_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      fifoEmpty,
  input  opCode_e   opCode,
  input  logic      fieldZero,
  input  logic      delayLast,
  input  logic      timeMatch,
  input  logic      modeBypass,
  input  logic      timeTick,
  input  logic      aerAck,
  input  logic      bypReady,
  output dpStrobe_t strb,
  output logic      fifoRead,
  output logic      aerReq,
  output logic      bypValid,
  output logic      busy
);

  seqState_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    strb     = '0;
    fifoRead = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.latchMode = 1'b1;
          nxt            = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (fifoEmpty) begin
          nxt = ST_IDLE;
        end else begin
          fifoRead     = 1'b1;
          strb.loadCmd = 1'b1;
          nxt          = ST_EXEC;
        end
      end
      ST_EXEC: begin
        unique case (opCode)
          OP_END:  nxt = ST_IDLE;
          OP_EMIT: nxt = modeBypass ? ST_BYP : ST_AER_REQ;
          OP_DELAY: begin
            strb.loadDelay = 1'b1;
            nxt            = fieldZero ? ST_FETCH : ST_DELAY;
          end
          OP_WAIT: nxt = ST_WAIT;
          default: nxt = ST_IDLE;
        endcase
      end
      ST_AER_REQ: if (aerAck)   nxt = ST_AER_REL;
      ST_AER_REL: if (!aerAck)  nxt = ST_FETCH;
      ST_BYP:     if (bypReady) nxt = ST_FETCH;
      ST_DELAY: begin
        strb.decDelay = timeTick;
        if (timeTick && delayLast) nxt = ST_FETCH;
      end
      ST_WAIT:    if (timeMatch) nxt = ST_FETCH;
      default:    nxt = ST_IDLE;
    endcase
  end

  assign aerReq   = (state == ST_AER_REQ);
  assign bypValid = (state == ST_BYP);
  assign busy     = (state != ST_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    aerReq && !aerAck |=> aerReq); // R7
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    aerReq && aerAck |=> !aerReq); // R7
  AST_FETCH_ACK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |-> !aerAck); // R7
  AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    bypValid && !bypReady |=> bypValid); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse)); // R10
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC) && (opCode == OP_END) |=> !busy); // R3

endmodule

// File: rtl/aer_cmd_seq.sv
module aer_cmd_seq
  import aer_seq_pkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int TIME_W  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic                 bypassMode,
  input  logic [FIELD_W+1:0]   fifoData,
  input  logic                 fifoEmpty,
  output logic                 fifoRead,
  input  logic [TIME_W-1:0]    sysTime,
  input  logic                 timeTick,
  output logic                 aerReq,
  output logic [FIELD_W-1:0]   aerAddr,
  input  logic                 aerAck,
  output logic                 bypValid,
  output logic [FIELD_W-1:0]   bypAddr,
  input  logic                 bypReady,
  output logic                 busy
);

  dpStrobe_t          strb;
  opCode_e            opCode;
  logic [FIELD_W-1:0] evAddr;
  logic               fieldZero, delayLast, timeMatch, modeBypass;

  aer_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .fifoEmpty  (fifoEmpty),
    .opCode     (opCode),
    .fieldZero  (fieldZero),
    .delayLast  (delayLast),
    .timeMatch  (timeMatch),
    .modeBypass (modeBypass),
    .timeTick   (timeTick),
    .aerAck     (aerAck),
    .bypReady   (bypReady),
    .strb       (strb),
    .fifoRead   (fifoRead),
    .aerReq     (aerReq),
    .bypValid   (bypValid),
    .busy       (busy)
  );

  aer_seq_dp #(
    .FIELD_W (FIELD_W),
    .TIME_W  (TIME_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .fifoData   (fifoData),
    .bypassIn   (bypassMode),
    .sysTime    (sysTime),
    .timeTick   (timeTick),
    .opCode     (opCode),
    .evAddr     (evAddr),
    .fieldZero  (fieldZero),
    .delayLast  (delayLast),
    .timeMatch  (timeMatch),
    .modeBypass (modeBypass)
  );

  assign aerAddr = evAddr;
  assign bypAddr = evAddr;

endmodule

// File: tb/aer_cmd_seq_tb.sv
module aer_cmd_seq_tb;

  localparam int FW = 16;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          bypassMode = 1'b0;
  logic [FW+1:0] fifoData = '0;
  logic          fifoEmpty = 1'b1;
  logic          fifoRead;
  logic [TW-1:0] sysTime = 32'd100;
  logic          timeTick = 1'b0;
  logic          aerReq;
  logic [FW-1:0] aerAddr;
  logic          aerAck = 1'b0;
  logic          bypValid;
  logic [FW-1:0] bypAddr;
  logic          bypReady = 1'b0;
  logic          busy;

  aer_cmd_seq #(.FIELD_W(FW), .TIME_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .bypassMode(bypassMode),
    .fifoData(fifoData), .fifoEmpty(fifoEmpty), .fifoRead(fifoRead),
    .sysTime(sysTime), .timeTick(timeTick),
    .aerReq(aerReq), .aerAddr(aerAddr), .aerAck(aerAck),
    .bypValid(bypValid), .bypAddr(bypAddr), .bypReady(bypReady),
    .busy(busy)
  );

  initial forever #10 clk = ~clk;

  logic [FW+1:0] fifoQ[$];
  logic [FW+1:0] progW[$];
  logic [FW-1:0] expAddrQ[$];
  int unsigned   expTimeQ[$];
  string         expTagQ[$];

  int nChecks = 0, nFails = 0;
  bit kick = 0, runBypass = 0, lastRead = 0;
  bit prevReq = 0, prevValid = 0, prevAck = 0, prevReady = 0, prevStart = 0, prevBusy = 0;
  bit badPop = 0, badAckFetch = 0;
  logic [FW-1:0] prevBypAddr = '0;
  int ackWait = 0, quiet = 0, sinceTick = 0, cycles = 0;
  int unsigned curT = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finishAll();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  function automatic logic [FW+1:0] mkWord(logic [1:0] op, logic [FW-1:0] f);
    return {op, f};
  endfunction

  // Program builders compute the expected event stream and event times
  task automatic beginProg();
    progW.delete(); expAddrQ.delete(); expTimeQ.delete(); expTagQ.delete();
    curT = sysTime;
  endtask
  task automatic addEmit(logic [FW-1:0] a, string tag);
    progW.push_back(mkWord(2'b01, a));
    expAddrQ.push_back(a); expTimeQ.push_back(curT); expTagQ.push_back(tag);
  endtask
  task automatic addDelay(int n);
    progW.push_back(mkWord(2'b10, FW'(n)));
    curT += n;
  endtask
  task automatic addWait(int ahead);
    int unsigned tgt;
    tgt = curT + ahead;
    progW.push_back(mkWord(2'b11, tgt[FW-1:0]));
    curT = tgt + 1;
  endtask
  task automatic addEnd();
    progW.push_back(mkWord(2'b00, '0));
  endtask

  task automatic gotEvent(logic [FW-1:0] a, bit viaByp);
    if (expAddrQ.size() == 0) begin
      check(0, "R4", "unexpected event address", a, -1);
    end else begin
      logic [FW-1:0] ea;
      int unsigned et;
      string tg;
      ea = expAddrQ.pop_front(); et = expTimeQ.pop_front(); tg = expTagQ.pop_front();
      check(a == ea, "R4", "event address", a, ea);
      check(sysTime == et, tg, "time at event", sysTime, et);
      check(viaByp == runBypass, "R8", "event path (1=bypass)", viaByp, runBypass);
    end
  endtask

  // Single process for all port driving and sampling at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 190000) begin
        nFails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 190000);
        finishAll();
      end
      if (rstN) begin
        if (timeTick) begin sysTime = sysTime + 1; timeTick = 1'b0; end
        if (lastRead) void'(fifoQ.pop_front());
        if (prevStart && !prevBusy) check(busy, "R10", "busy after start", busy, 1);
        if (aerReq && !prevReq)     gotEvent(aerAddr, 1'b0);
        if (bypValid && !prevValid) gotEvent(bypAddr, 1'b1);
        if (prevReq && !prevAck)    check(aerReq, "R7", "req held before ack", aerReq, 1);
        if (prevReq && prevAck)     check(!aerReq, "R7", "req dropped after ack", aerReq, 0);
        if (prevValid && !prevReady) begin
          check(bypValid, "R8", "valid held before ready", bypValid, 1);
          check(bypAddr == prevBypAddr, "R8", "bypass address stable", bypAddr, prevBypAddr);
        end
        // four-phase responder
        if (aerReq && !aerAck) begin
          if (ackWait > 0) ackWait--; else begin aerAck = 1'b1; ackWait = $urandom_range(0, 2); end
        end else if (!aerReq && aerAck) begin
          if (ackWait > 0) ackWait--; else begin aerAck = 1'b0; ackWait = $urandom_range(0, 2); end
        end
        bypReady = ($urandom_range(0, 2) == 0);
        startPulse = kick;
        kick = 1'b0;
        if (aerReq || aerAck || bypValid || startPulse) quiet = 0; else quiet++;
        if (busy && quiet >= 8 && sinceTick >= 10 && $urandom_range(0, 1) == 1) begin
          timeTick = 1'b1; sinceTick = 0;
        end else begin
          sinceTick++;
        end
        fifoEmpty = (fifoQ.size() == 0);
        fifoData  = fifoEmpty ? '0 : fifoQ[0];
        #1;
        lastRead = fifoRead;
        if (fifoRead && fifoEmpty) badPop = 1'b1;
        if (fifoRead && aerAck)    badAckFetch = 1'b1;
        prevReq = aerReq; prevValid = bypValid; prevAck = aerAck; prevReady = bypReady;
        prevBypAddr = bypAddr; prevStart = startPulse; prevBusy = busy;
      end
    end
  end

  task automatic runProg(bit byp, int expLeft, bit restartMid, string tag);
    int guard;
    fifoQ = progW;
    runBypass = byp;
    bypassMode = byp;
    kick = 1'b1;
    guard = 0;
    @(negedge clk); #5;
    while (!busy && guard < 50) begin @(negedge clk); #5; guard++; end
    if (restartMid) begin
      repeat (3) begin @(negedge clk); #5; end
      kick = 1'b1; // R2: start while busy must be ignored
    end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); #5; guard++; end
    check(guard < 20000, "R10", "busy fell at end", guard, 0);
    @(negedge clk); #5;
    check(expAddrQ.size() == 0, "R4", "events still missing", expAddrQ.size(), 0);
    check(fifoQ.size() == expLeft, tag, "words left in FIFO", fifoQ.size(), expLeft);
    check(!badPop, "R9", "pop while empty", badPop, 0);
    check(!badAckFetch, "R7", "fetch while ack high", badAckFetch, 0);
    badPop = 1'b0; badAckFetch = 1'b0;
    repeat (4) begin @(negedge clk); #5; end
  endtask

  initial begin
    void'($urandom(32'd1234));
    fifoEmpty = 1'b0;
    fifoData  = mkWord(2'b01, 16'hAAAA);
    repeat (3) @(negedge clk);
    #5;
    check(!busy,     "R1", "busy in reset",     busy, 0);
    check(!aerReq,   "R1", "aerReq in reset",   aerReq, 0);
    check(!bypValid, "R1", "bypValid in reset", bypValid, 0);
    check(!fifoRead, "R1", "fifoRead in reset", fifoRead, 0);
    rstN = 1'b1;
    repeat (2) begin @(negedge clk); #5; end

    // R3 end command leaves the trailing word unread
    beginProg(); addEmit(16'h1234, "R4"); addDelay(3); addEmit(16'hBEEF, "R5");
    addEnd(); progW.push_back(mkWord(2'b01, 16'h5555));
    runProg(1'b0, 1, 1'b0, "R3");

    // R5 zero delay
    beginProg(); addEmit(16'h0001, "R4"); addDelay(0); addEmit(16'h0002, "R5"); addEnd();
    runProg(1'b0, 0, 1'b0, "R5");

    // R6 wait for current time, for a later time, and after a delay
    beginProg(); addWait(0); addEmit(16'h0A0A, "R6"); addWait(2); addEmit(16'h0B0B, "R6");
    addDelay(2); addWait(1); addEmit(16'h0C0C, "R6"); addEnd();
    runProg(1'b0, 0, 1'b0, "R6");

    // R9 run out of words without an end command
    beginProg(); addEmit(16'h7001, "R4"); addDelay(1); addEmit(16'h7002, "R5");
    runProg(1'b0, 0, 1'b0, "R9");

    // R3 immediate end with two words behind it
    beginProg(); addEnd(); progW.push_back(mkWord(2'b10, 16'd4)); progW.push_back(mkWord(2'b00, '0));
    runProg(1'b0, 2, 1'b0, "R3");

    // R9 start with an empty FIFO
    beginProg();
    runProg(1'b0, 0, 1'b0, "R9");

    // R8 bypass path
    beginProg(); addEmit(16'h8001, "R8"); addEmit(16'h8002, "R8"); addDelay(2);
    addEmit(16'h8003, "R5"); addWait(1); addEmit(16'h8004, "R6"); addEnd();
    progW.push_back(mkWord(2'b01, 16'h8FFF));
    runProg(1'b1, 1, 1'b0, "R8");

    // R2 restart while busy
    beginProg(); addEmit(16'h2001, "R2"); addDelay(4); addEmit(16'h2002, "R2"); addEnd();
    progW.push_back(mkWord(2'b01, 16'h2FFF));
    runProg(1'b0, 1, 1'b1, "R2");

    // random programs, alternating modes
    for (int run = 0; run < 24; run++) begin
      int nCmd, left;
      bit byp;
      byp = run[0];
      beginProg();
      nCmd = $urandom_range(3, 10);
      for (int k = 0; k < nCmd; k++) begin
        case ($urandom_range(0, 3))
          0, 1: addEmit(FW'($urandom_range(0, 65535)), "R5");
          2:    addDelay($urandom_range(1, 6));
          default: addWait($urandom_range(0, 3));
        endcase
      end
      left = 0;
      if ($urandom_range(0, 1) == 1) begin
        addEnd();
        left = $urandom_range(0, 2);
        for (int j = 0; j < left; j++) progW.push_back(FW'($urandom_range(0, 65535)) | (18'h1 << 16));
      end
      runProg(byp, left, 1'b0, left > 0 ? "R3" : "R9");
    end

    finishAll();
  end

endmodule